// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block sits between a 32-bit register bus and an external successive-approximation converter with sixteen analog inputs. Software programs a control word (engine on/off, a three-bit power mode, a sixteen-bit channel enable mask) and a clock word (a divisor and a pre-divisor). While the engine is on and in normal mode, the block derives a conversion clock from the bus clock. It then visits the enabled inputs one after another, asking the converter for one sample per visit.

Each sample is a 10-bit value. It is captured when its fixed conversion window ends and is kept in packed result words that software reads over the same bus. The converter itself is outside the block. The block hands it a channel number, a one-cycle start strobe and the conversion clock, and it samples the converter's result lines at the end of the window.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word, the clock word and every result word read as zero, and no start strobe is issued.
- R2: The control word sits at offset 0x00. Bit 0 is the engine enable, bits 3:1 are the power mode (0 power-down, 1 standby, 7 normal) and bits 31:16 are the channel enable mask (bit 16 + n enables channel n). It reads back as written, with unused bits zero.
- R3: The clock word sits at offset 0x0C. Bits 9:0 hold the divisor and bits 24:17 hold the pre-divisor. It reads back as written, with all other bits zero.
- R4: One conversion-clock period lasts 2 × (pre-divisor + 1) × (divisor + 1) bus clocks. A conversion spans 12 such periods, so back-to-back start strobes are exactly 24 × (pre + 1) × (div + 1) bus clocks apart.
- R5: Start strobes occur only while the enable bit is 1 and the mode field is 7. Power-down, standby or a cleared enable bit start nothing.
- R6: Enabled channels are visited in ascending index order. Disabled channels are skipped, and the scan wraps from the highest enabled channel back to the lowest. The first visit after reset goes to the lowest enabled channel, and after a stop the scan resumes with the channel following the last one started.
- R7: With an all-zero enable mask no conversion starts.
- R8: Channel n's result is kept in the word at offset 0x10 + 4 × (n / 2). An even channel occupies bits 9:0 and an odd channel occupies bits 25:16. All other bits read zero.
- R9: A channel's result field changes only when that channel's conversion completes. It then holds the value present on the converter result input at the end of the 12th conversion-clock period. Bus reads have no side effects.
- R10: Clearing the enable bit or leaving normal mode aborts the conversion in progress without storing it and returns the clock divider to its start phase. Stored results are kept.
- R11: A new clock word takes effect only at a conversion-clock boundary. Every high phase of the conversion clock lasts (pre + 1) × (div + 1) bus clocks for a single setting, never a truncated mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational, side-effect free) |
| conv_clk | output | 1 | Derived conversion clock, low while idle |
| conv_start | output | 1 | One-cycle strobe that begins a conversion |
| conv_chan | output | 4 | Channel being converted |
| conv_result | input | 10 | Converter result, sampled at the end of the conversion window |

## Verification
The bench aims first at the scan order with a sparse mask that includes both the lowest and the highest channel. A design that mishandles the wrap or the skip would strobe a disabled channel or repeat one. The bench times the spacing of start strobes and the width of every conversion-clock high phase, including across a divisor rewrite during a conversion. An off-by-one in either divider stage, or a divisor loaded mid-period, shows up as a wrong interval or a chopped pulse.

The bench aborts scans by clearing the enable bit and by switching to standby, then reads every result word twice. A design that stored an aborted sample, lost earlier results or let reads disturb them fails these reads. The bench also holds the engine in power-down, in standby, with enable cleared and with an empty mask. A design that gates on the enable bit alone would issue strobes there.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   // Register byte offsets
   localparam int OFF_CTRL = 'h00;
   localparam int OFF_CLK  = 'h0C;
   localparam int OFF_DATA = 'h10;

   // Bit placement inside the control and clock words
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_MODE_LSB = 1;
   localparam int CTRL_MASK_LSB = 16;
   localparam int CLK_PRE_LSB   = 17;

   typedef enum logic [2:0] {
      PWR_OFF  = 3'd0,
      PWR_STBY = 3'd1,
      PWR_RUN  = 3'd7
   } pwr_mode_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_CONV = 1'b1
   } seq_state_e;

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
   parameter int DIV_W = 10,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_req,
   input  logic [PRE_W-1:0] pre_req,
   output logic             tick,
   output logic             adc_clk,
   output logic [DIV_W-1:0] div_act,
   output logic [PRE_W-1:0] pre_act
);

   logic [DIV_W-1:0] dcnt;
   logic [PRE_W-1:0] pcnt;
   logic             half;
   logic             d_end;
   logic             p_end;

   assign d_end   = (dcnt == div_act);
   assign p_end   = (pcnt == pre_act);
   assign tick    = run & d_end & p_end & half;
   assign adc_clk = run & ~half;

   // Inner stage counts div+1 cycles, outer stage counts pre+1 inner wraps,
   // the half bit doubles the result. Settings reload only on a full period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt    <= '0;
         pcnt    <= '0;
         half    <= 1'b0;
         div_act <= '0;
         pre_act <= '0;
      end else if (!run) begin
         dcnt    <= '0;
         pcnt    <= '0;
         half    <= 1'b0;
         div_act <= div_req;
         pre_act <= pre_req;
      end else if (d_end) begin
         dcnt <= '0;
         if (p_end) begin
            pcnt <= '0;
            half <= ~half;
            if (half) begin
               div_act <= div_req;
               pre_act <= pre_req;
            end
         end else begin
            pcnt <= pcnt + 1'b1;
         end
      end else begin
         dcnt <= dcnt + 1'b1;
      end
   end

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int NCH = 16,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic [NCH-1:0]  mask,
   input  logic [CH_W-1:0] cur,
   output logic [CH_W-1:0] nxt,
   output logic            any
);

   // Search forward from cur+1 with wrap; the closest enabled index wins.
   always_comb begin
      nxt = cur;
      any = |mask;
      for (int k = NCH; k >= 1; k--) begin
         int j;
         j = (int'(cur) + k) % NCH;
         if (mask[j]) nxt = CH_W'(j);
      end
   end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH   = 16,
   parameter int RES_W = 10,
   parameter int AW    = 6,
   parameter int BASE  = 16,
   localparam int CH_W = $clog2(NCH),
   localparam int NW   = NCH / 2,
   localparam int WIX  = (NW > 1) ? $clog2(NW) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CH_W-1:0]  wch,
   input  logic [RES_W-1:0] wdata,
   input  logic [AW-1:0]    rd_addr,
   output logic [31:0]      rd_data
);

   logic [RES_W-1:0] res [NCH];
   logic [31:0]      words [NW];
   logic [AW-1:0]    off;
   logic [AW-3:0]    widx;
   logic             hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) res[c] <= '0;
      end else if (we) begin
         res[wch] <= wdata;
      end
   end

   // Pack two results per word: even channel low half, odd channel high half
   for (genvar w = 0; w < NW; w++) begin : g_word
      assign words[w] = {{(16-RES_W){1'b0}}, res[2*w+1],
                         {(16-RES_W){1'b0}}, res[2*w]};
   end

   assign off  = rd_addr - AW'(BASE);
   assign widx = off[AW-1:2];
   assign hit  = (rd_addr >= AW'(BASE)) && (off[1:0] == 2'b00) &&
                 (int'(widx) < NW);

   always_comb begin
      rd_data = '0;
      if (hit) rd_data = words[widx[WIX-1:0]];
   end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int RES_W       = 10,
   parameter int DIV_W       = 10,
   parameter int PRE_W       = 8,
   parameter int SAMPLE_CLKS = 12,
   parameter int AW          = 6,
   localparam int CH_W       = $clog2(NCH),
   localparam int TC_W       = $clog2(SAMPLE_CLKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [AW-1:0]    bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             conv_clk,
   output logic             conv_start,
   output logic [CH_W-1:0]  conv_chan,
   input  logic [RES_W-1:0] conv_result
);

   // Elaboration-time parameter checks
   if (NCH < 2 || NCH > 16 || (NCH % 2) != 0)
      $error("adc_scan_seq: NCH must be even and within 2..16");
   if (RES_W < 1 || RES_W > 16)
      $error("adc_scan_seq: RES_W must fit a half word");
   if (DIV_W < 1 || DIV_W > CLK_PRE_LSB)
      $error("adc_scan_seq: DIV_W overlaps the pre-divisor field");
   if (PRE_W < 1 || CLK_PRE_LSB + PRE_W > 32)
      $error("adc_scan_seq: PRE_W does not fit the clock word");
   if (SAMPLE_CLKS < 2)
      $error("adc_scan_seq: SAMPLE_CLKS must be at least 2");
   if ((1 << AW) < OFF_DATA + 4 * (NCH / 2))
      $error("adc_scan_seq: AW too narrow for the result words");

   // Software-visible settings
   logic             ctl_en;
   logic [2:0]       ctl_mode;
   logic [NCH-1:0]   ctl_mask;
   logic [DIV_W-1:0] clk_div;
   logic [PRE_W-1:0] clk_pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en   <= 1'b0;
         ctl_mode <= PWR_OFF;
         ctl_mask <= '0;
         clk_div  <= '0;
         clk_pre  <= '0;
      end else if (bus_we) begin
         if (bus_addr == AW'(OFF_CTRL)) begin
            ctl_en   <= bus_wdata[CTRL_EN_BIT];
            ctl_mode <= bus_wdata[CTRL_MODE_LSB +: 3];
            ctl_mask <= bus_wdata[CTRL_MASK_LSB +: NCH];
         end else if (bus_addr == AW'(OFF_CLK)) begin
            clk_div <= bus_wdata[DIV_W-1:0];
            clk_pre <= bus_wdata[CLK_PRE_LSB +: PRE_W];
         end
      end
   end

   logic run;
   assign run = ctl_en && (ctl_mode == PWR_RUN);

   // Sequencer state
   seq_state_e       state;
   logic [CH_W-1:0]  cur_ch;
   logic [TC_W-1:0]  tcnt;
   logic             busy;
   logic             div_run;
   logic             tick;
   logic             last_tick;
   logic             st_we;
   logic [CH_W-1:0]  nxt_ch;
   logic             any_en;
   logic [DIV_W-1:0] div_act;
   logic [PRE_W-1:0] pre_act;

   assign busy      = (state == SEQ_CONV);
   assign div_run   = run && busy;
   assign last_tick = (tcnt == TC_W'(SAMPLE_CLKS - 1));
   assign st_we     = busy && tick && last_tick;

   adc_clk_gen #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (div_run),
      .div_req (clk_div),
      .pre_req (clk_pre),
      .tick    (tick),
      .adc_clk (conv_clk),
      .div_act (div_act),
      .pre_act (pre_act)
   );

   adc_chan_pick #(.NCH(NCH)) u_pick (
      .mask (ctl_mask),
      .cur  (cur_ch),
      .nxt  (nxt_ch),
      .any  (any_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         cur_ch     <= CH_W'(NCH - 1);
         tcnt       <= '0;
         conv_start <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         if (!run) begin
            state <= SEQ_IDLE;
            tcnt  <= '0;
         end else begin
            case (state)
               SEQ_IDLE: begin
                  if (any_en) begin
                     state      <= SEQ_CONV;
                     cur_ch     <= nxt_ch;
                     conv_start <= 1'b1;
                     tcnt       <= '0;
                  end
               end
               SEQ_CONV: begin
                  if (tick) begin
                     if (last_tick) begin
                        tcnt <= '0;
                        if (any_en) begin
                           cur_ch     <= nxt_ch;
                           conv_start <= 1'b1;
                        end else begin
                           state <= SEQ_IDLE;
                        end
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               default: state <= SEQ_IDLE;
            endcase
         end
      end
   end

   assign conv_chan = cur_ch;

   logic [31:0] bank_rd;

   adc_result_bank #(.NCH(NCH), .RES_W(RES_W), .AW(AW), .BASE(OFF_DATA)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (st_we),
      .wch     (cur_ch),
      .wdata   (conv_result),
      .rd_addr (bus_addr),
      .rd_data (bank_rd)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(OFF_CTRL)) begin
         bus_rdata[CTRL_EN_BIT]            = ctl_en;
         bus_rdata[CTRL_MODE_LSB +: 3]     = ctl_mode;
         bus_rdata[CTRL_MASK_LSB +: NCH]   = ctl_mask;
      end else if (bus_addr == AW'(OFF_CLK)) begin
         bus_rdata[DIV_W-1:0]              = clk_div;
         bus_rdata[CLK_PRE_LSB +: PRE_W]   = clk_pre;
      end else begin
         bus_rdata = bank_rd;
      end
   end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter int NCH   = 16,
   parameter int DIV_W = 10,
   parameter int PRE_W = 8,
   localparam int CH_W = $clog2(NCH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             busy,
   input logic             div_run,
   input logic             tick,
   input logic             conv_start,
   input logic [CH_W-1:0]  conv_chan,
   input logic [NCH-1:0]   ctl_mask,
   input logic [DIV_W-1:0] div_act,
   input logic [PRE_W-1:0] pre_act
);

   logic [NCH-1:0] mask_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= ctl_mask;
   end

   assert_start_in_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(run));

   assert_start_on_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> mask_q[conv_chan]);

   assert_empty_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_mask == '0) |=> !conv_start);

   assert_start_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_abort_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !run) |=> !busy);

   assert_divisor_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (div_run && !tick) |=> ($stable(div_act) && $stable(pre_act)));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .DIV_W(DIV_W), .PRE_W(PRE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .busy       (busy),
   .div_run    (div_run),
   .tick       (tick),
   .conv_start (conv_start),
   .conv_chan  (conv_chan),
   .ctl_mask   (ctl_mask),
   .div_act    (div_act),
   .pre_act    (pre_act)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        conv_clk;
   logic        conv_start;
   logic [3:0]  conv_chan;
   logic [9:0]  conv_result = '0;

   always #2 clk = ~clk;   // 250 MHz

   adc_scan_seq u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_clk(conv_clk),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_result(conv_result)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   // Scoreboard state
   int         exp_q[$];
   int         nstarts   = 0;
   int         last_seen = 15;
   int         last_t    = 0;
   int         exp_int   = 0;
   int         int_skip  = 0;
   bit         pend_v    = 0;
   int         pend_ch   = 0;
   logic [9:0] pend_res  = '0;
   logic [9:0] exp_data [16];
   int         half_a = 1, half_b = 1;
   bit         cc_chk = 0;
   int         hi_len = 0;
   logic       cc_prev = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Monitor: pops expected channels as starts appear, models the converter
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (conv_start) begin
            nstarts++;
            if (exp_q.size() == 0) begin
               check(0, "R5/R7 unexpected start", conv_chan, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(int'(conv_chan) == e, "R6 scan order", conv_chan, e);
            end
            if (int_skip > 0) int_skip--;
            else check(cyc - last_t == exp_int, "R4 start spacing", cyc - last_t, exp_int);
            last_t = cyc;
            if (pend_v) exp_data[pend_ch] = pend_res;   // R9 completion store
            pend_ch  = int'(conv_chan);
            pend_res = 10'((int'(conv_chan) * 61 + nstarts * 7 + 3) % 1024);
            conv_result = pend_res;
            pend_v    = 1;
            last_seen = int'(conv_chan);
         end
         // R11: width of each high phase of the conversion clock
         if (conv_clk) hi_len++;
         if (cc_prev && !conv_clk) begin
            if (cc_chk)
               check(hi_len == half_a || hi_len == half_b, "R11 clock high phase", hi_len, half_a);
            hi_len = 0;
         end
         cc_prev = conv_clk;
      end
   end

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(a);
      #1 d = bus_rdata;
   endtask

   task automatic push_seq(input logic [15:0] m, input int n);
      int c;
      c = last_seen;
      for (int i = 0; i < n; i++) begin
         do c = (c + 1) % 16; while (!m[c]);
         exp_q.push_back(c);
      end
   endtask

   task automatic wait_starts(input int target);
      while (nstarts < target && !done) @(negedge clk);
   endtask

   task automatic check_words(input string req);
      logic [31:0] d;
      for (int w = 0; w < 8; w++) begin
         logic [31:0] e;
         e = {6'b0, exp_data[2*w+1], 6'b0, exp_data[2*w]};
         bus_read(16 + 4 * w, d);
         check(d === e, req, d, e);
      end
   endtask

   task automatic quiet_window(input string req);
      int n0;
      n0 = nstarts;
      repeat (400) @(negedge clk);
      check(nstarts == n0, req, nstarts - n0, 0);
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      localparam logic [15:0] M1 = 16'h8425;   // channels 0,2,5,10,15
      for (int c = 0; c < 16; c++) exp_data[c] = '0;
      repeat (3) @(negedge clk);
      check(conv_start == 1'b0, "R1 no start in reset", conv_start, 0);
      rst_n = 1'b1;

      // R1: reset values
      bus_read(0, d);  check(d == 0, "R1 control reset", d, 0);
      bus_read(12, d); check(d == 0, "R1 clock reset", d, 0);
      check_words("R1 result reset");

      // R3: field placement and masking
      bus_write(12, 32'hFFFF_FFFF);
      bus_read(12, d); check(d == 32'h01FE_03FF, "R3 clock field mask", d, 32'h01FE_03FF);
      bus_write(12, (32'd1 << 17) | 32'd2);        // pre=1 div=2 -> half 6, P 12
      bus_read(12, d); check(d == 32'h0002_0002, "R3 clock readback", d, 32'h0002_0002);

      // R2 / R5: standby, power-down and enable-clear are quiet
      bus_write(0, {M1, 12'h0, 3'd1, 1'b1});
      bus_read(0, d); check(d == {M1, 16'h0003}, "R2 control readback", d, {M1, 16'h0003});
      quiet_window("R5 standby quiet");
      bus_write(0, {M1, 12'h0, 3'd0, 1'b1});
      quiet_window("R5 power-down quiet");
      bus_write(0, {M1, 12'h0, 3'd7, 1'b0});
      quiet_window("R5 enable clear quiet");
      bus_write(0, 32'hFFFF_0000 & 32'h0000_FFFF | {16'h0, 12'h0, 3'd7, 1'b1});
      quiet_window("R7 empty mask quiet");
      bus_read(0, d); check(d == 32'h0000_000F, "R2 mode field", d, 32'h0000_000F);

      // R4 / R6 / R11: scan with a sparse mask, wrap included
      exp_int = 144; int_skip = 1; half_a = 6; half_b = 6; cc_chk = 1;
      push_seq(M1, 12);
      bus_write(0, {M1, 12'h0, 3'd7, 1'b1});
      wait_starts(12);

      // R10: abort by clearing enable; in-flight sample dropped
      cc_chk = 0;
      bus_write(0, {M1, 12'h0, 3'd7, 1'b0});
      pend_v = 0; exp_q.delete();
      repeat (20) @(negedge clk);
      check(conv_clk == 1'b0, "R10 divider reset", conv_clk, 0);
      check_words("R8 packed results after abort");
      check_words("R9 reread has no side effect");
      repeat (300) @(negedge clk);
      check_words("R10 results retained");

      // R6 resume after abort, R11 divisor change mid-conversion
      bus_write(12, 32'd0);                         // half 1, P 2
      exp_int = 24; int_skip = 1; half_a = 1; half_b = 1; cc_chk = 1; hi_len = 0;
      push_seq(16'h00F3, 16);
      bus_write(0, {16'h00F3, 12'h0, 3'd7, 1'b1});
      wait_starts(15);
      half_b = 4; int_skip = 2;
      bus_write(12, 32'd3);                         // half 4, P 8
      wait_starts(17);
      half_a = 4; exp_int = 96;
      wait_starts(28);

      // R10: abort by leaving normal mode
      cc_chk = 0;
      bus_write(0, {16'h00F3, 12'h0, 3'd1, 1'b1});
      pend_v = 0; exp_q.delete();
      repeat (120) @(negedge clk);
      check_words("R8 R10 results after standby abort");
      check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule